// File: doc/BRIEF.md
# Programmable Interval Timer Host Register Port

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a 2-bit address: addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 is the control port. Control writes program a channel's operating mode, count format and byte access order, or they capture a channel's count and status for a clean read. Data writes assemble bytes into a 16-bit initial count. Data reads return either a captured byte or the live count supplied by the counting engine.

The counting engine sits beside this block. It supplies each channel's live count, which is always binary, and its output level. It pulses `loaded_i` when it has taken a new initial count. In return it receives each channel's configuration, a one-cycle new-count strobe and the initial count. The initial count is binary even when the channel is programmed for decimal counting.

Top module: `tmr_host_port`

## Requirements
- R1: A write to address 3 with bits 7:6 = 0, 1 or 2 (channel) and bits 5:4 nonzero loads that channel's format flag (bit 0), mode (bits 3:1) and access order (bits 5:4). The new values are visible on `bcd_o`, `mode_o` and `acc_o` one cycle after the write. After reset every channel has mode 0, binary format and access order 3.
- R2: A configuring write as in R1 discards the channel's captured count, captured status, read byte toggle and write byte toggle, and it sets the null-count flag. Until the engine pulses `loaded_i`, the status output bit reads 0 if the new mode is 0 and 1 for any other mode. After that pulse it follows `out_lvl_i`.
- R3: A write to address 3 with bits 5:4 = 0 and bits 7:6 = 0, 1 or 2 captures that channel's count and leaves its configuration unchanged. Reads then return the captured bytes even if the live count changes meanwhile.
- R4: With access order 1 (low only), each data write commits the initial count {8'h00, data}. With access order 2 (high only), each data write commits {data, 8'h00}. In both cases `load_o` pulses for the one cycle after the write.
- R5: With access order 3, data writes alternate: the first byte is the low half and the second is the high half. Only the second write commits the count and pulses `load_o`.
- R6: Data reads return the low byte under access order 1 and the high byte under access order 2. Under access order 3 they alternate, starting with the low byte. This applies both to live reads and to captured counts, so a captured count under order 2 yields its high byte.
- R7: A count capture request is ignored while a previously captured count of that channel still has unread bytes. A status capture request is ignored while a captured status byte is unread.
- R8: A write to address 3 with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2, and every selected channel is served. Bit 5 = 0 requests a count capture and bit 4 = 0 requests a status capture. When both are captured, the status byte is read first. Reading the status byte does not advance the read byte toggle.
- R9: The status byte holds the output level in bit 7, the null-count flag in bit 6, the access order in bits 5:4, the mode in bits 3:1 and the format flag in bit 0.
- R10: With the format flag set, written counts are taken as four decimal digits and converted to binary on `init_cnt_o`. Live and captured counts read back as the four decimal digits of the binary live count.
- R11: The null-count flag (`null_cnt_o`, status bit 6) is set by a committed count and cleared one cycle after `loaded_i`.
- R12: A read of address 3 returns 8'h00 and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe (ignored while wr_i is high) |
| addr_i | input | 2 | Register address, 3 = control |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data for addr_i |
| live_cnt_i | input | 48 | Live binary count per channel, channel i at bits 16i+15:16i |
| out_lvl_i | input | 3 | Engine output level per channel |
| loaded_i | input | 3 | Engine has taken the new initial count |
| mode_o | output | 9 | Mode per channel, 3 bits each |
| bcd_o | output | 3 | Decimal format flag per channel |
| acc_o | output | 6 | Access order per channel, 2 bits each |
| load_o | output | 3 | One-cycle new-count strobe per channel |
| init_cnt_o | output | 48 | Binary initial count per channel |
| null_cnt_o | output | 3 | Null-count flag per channel |

## Verification
Any state error in a channel shows up on `rdata_o` as soon as the host reads that port. A read toggle that is out of step returns the opposite byte on the very next read. A stale capture returns an old value where the live count was expected, and a capture that was wrongly accepted returns a newer value than the held one. Write-toggle or conversion errors appear on `init_cnt_o` and `load_o` in the cycle after the committing byte. Status errors appear in the first read after a read-back command. The directed sequences therefore read every port right after each command and compare byte by byte.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH    = 3;
  localparam int AW     = 2;
  localparam int DW     = 8;
  localparam int CW     = 16;
  localparam int DIGITS = CW / 4;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  typedef struct packed {
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } chan_cfg_t;

  function automatic logic [CW-1:0] dec_to_bin(input logic [CW-1:0] d);
    logic [CW-1:0] r;
    logic [CW-1:0] w;
    r = '0;
    w = CW'(1);
    for (int i = 0; i < DIGITS; i++) begin
      r = r + CW'(d[4*i +: 4]) * w;
      w = w * CW'(10);
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_bin2dec.sv
module tmr_bin2dec
  import tmr_pkg::*;
#(
  parameter int W = CW
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] dec_o
);
  localparam int ND = (W + 3) / 3 + 1;
  localparam int SW = W + 4 * ND;

  logic [SW-1:0] sh;

  // shift-and-add-3, keeps the lowest W/4 decimal digits
  always_comb begin
    sh = {{(4*ND){1'b0}}, bin_i};
    for (int i = 0; i < W; i++) begin
      for (int d = 0; d < ND; d++) begin
        if (sh[W + 4*d +: 4] >= 4'd5) sh[W + 4*d +: 4] = sh[W + 4*d +: 4] + 4'd3;
      end
      sh = sh << 1;
    end
    dec_o = sh[W +: W];
  end
endmodule

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
  import tmr_pkg::*;
(
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [NCH-1:0] cfg_wr_o,
  output logic [NCH-1:0] cnt_lat_o,
  output logic [NCH-1:0] st_lat_o,
  output logic [NCH-1:0] dat_wr_o,
  output logic [NCH-1:0] rd_o
);
  logic [1:0] sel;
  logic [1:0] acc;
  logic       ctl_wr;

  assign sel    = wdata_i[7:6];
  assign acc    = wdata_i[5:4];
  assign ctl_wr = wr_i && (addr_i == CTRL_ADDR);

  always_comb begin
    cfg_wr_o  = '0;
    cnt_lat_o = '0;
    st_lat_o  = '0;
    dat_wr_o  = '0;
    rd_o      = '0;
    for (int i = 0; i < NCH; i++) begin
      dat_wr_o[i] = wr_i && (addr_i == AW'(i));
      rd_o[i]     = rd_i && !wr_i && (addr_i == AW'(i));
      if (ctl_wr) begin
        if (sel == 2'd3) begin
          // read-back: serve every selected channel
          if (wdata_i[1+i]) begin
            cnt_lat_o[i] = !wdata_i[5];
            st_lat_o[i]  = !wdata_i[4];
          end
        end else if (sel == 2'(i)) begin
          if (acc == 2'd0) cnt_lat_o[i] = 1'b1;
          else             cfg_wr_o[i]  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_wr_i,
  input  logic          cnt_lat_i,
  input  logic          st_lat_i,
  input  logic          dat_wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] live_cnt_i,
  input  logic          out_lvl_i,
  input  logic          loaded_i,
  output chan_cfg_t     cfg_o,
  output logic          load_o,
  output logic [CW-1:0] init_cnt_o,
  output logic          null_cnt_o,
  output logic [DW-1:0] rdata_o
);
  chan_cfg_t     cfg_q;
  logic          wr_tog_q, rd_tog_q;
  logic [DW-1:0] lo_q;
  logic [1:0]    cnt_left_q;
  logic [CW-1:0] lat_q;
  logic          stat_vld_q;
  logic [DW-1:0] stat_q;
  logic          pend_q, null_q, load_q;
  logic [CW-1:0] init_q;

  logic [CW-1:0] dec_cnt, pres_cnt, src, raw;
  logic          out_now, commit, take_hi;
  logic [DW-1:0] stat_now;

  tmr_bin2dec #(.W(CW)) u_b2d (.bin_i(live_cnt_i), .dec_o(dec_cnt));

  assign pres_cnt = cfg_q.bcd ? dec_cnt : live_cnt_i;
  assign out_now  = pend_q ? (cfg_q.mode != 3'd0) : out_lvl_i;
  assign stat_now = {out_now, null_q, cfg_q.acc, cfg_q.mode, cfg_q.bcd};

  always_comb begin
    commit = 1'b0;
    raw    = '0;
    unique case (cfg_q.acc)
      2'd1: begin commit = dat_wr_i; raw = {8'h00, wdata_i}; end
      2'd2: begin commit = dat_wr_i; raw = {wdata_i, 8'h00}; end
      2'd3: begin commit = dat_wr_i && wr_tog_q; raw = {wdata_i, lo_q}; end
      default: ;
    endcase
  end

  always_comb begin
    src     = (cnt_left_q != 2'd0) ? lat_q : pres_cnt;
    take_hi = (cfg_q.acc == 2'd2) || ((cfg_q.acc == 2'd3) && rd_tog_q);
    rdata_o = stat_vld_q ? stat_q : (take_hi ? src[15:8] : src[7:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '{acc: 2'd3, mode: 3'd0, bcd: 1'b0};
      wr_tog_q   <= 1'b0;
      rd_tog_q   <= 1'b0;
      lo_q       <= '0;
      cnt_left_q <= '0;
      lat_q      <= '0;
      stat_vld_q <= 1'b0;
      stat_q     <= '0;
      pend_q     <= 1'b1;
      null_q     <= 1'b1;
      load_q     <= 1'b0;
      init_q     <= '0;
    end else begin
      load_q <= 1'b0;
      if (cfg_wr_i) begin
        cfg_q      <= chan_cfg_t'(wdata_i[5:0]);
        wr_tog_q   <= 1'b0;
        rd_tog_q   <= 1'b0;
        lo_q       <= '0;
        cnt_left_q <= '0;
        stat_vld_q <= 1'b0;
        pend_q     <= 1'b1;
        null_q     <= 1'b1;
      end else begin
        if (commit) begin
          init_q <= cfg_q.bcd ? dec_to_bin(raw) : raw;
          load_q <= 1'b1;
          null_q <= 1'b1;
        end else if (loaded_i) begin
          null_q <= 1'b0;
        end
        if (loaded_i) pend_q <= 1'b0;
        if (dat_wr_i && cfg_q.acc == 2'd3) begin
          wr_tog_q <= !wr_tog_q;
          if (!wr_tog_q) lo_q <= wdata_i;
        end
        if (rd_i) begin
          if (stat_vld_q) begin
            stat_vld_q <= 1'b0;
          end else begin
            if (cnt_left_q != 2'd0) cnt_left_q <= cnt_left_q - 2'd1;
            if (cfg_q.acc == 2'd3)  rd_tog_q   <= !rd_tog_q;
          end
        end else begin
          if (cnt_lat_i && cnt_left_q == 2'd0) begin
            lat_q      <= pres_cnt;
            cnt_left_q <= (cfg_q.acc == 2'd3) ? 2'd2 : 2'd1;
            rd_tog_q   <= 1'b0;
          end
          if (st_lat_i && !stat_vld_q) begin
            stat_q     <= stat_now;
            stat_vld_q <= 1'b1;
          end
        end
      end
    end
  end

  assign cfg_o      = cfg_q;
  assign load_o     = load_q;
  assign init_cnt_o = init_q;
  assign null_cnt_o = null_q;

  // R4
  load_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> $past(dat_wr_i));
  // R2
  cfg_sets_null_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> null_q);
  // R7
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_left_q != 2'd0) && cnt_lat_i && !cfg_wr_i && !rd_i |=> $stable(lat_q));
  // R7
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_vld_q && st_lat_i && !cfg_wr_i && !rd_i |=> $stable(stat_q));
  // R6
  left_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_left_q != 2'd3);
  // R11
  null_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_i && !cfg_wr_i && !commit |=> !null_q);
endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NCH*CW-1:0] live_cnt_i,
  input  logic [NCH-1:0]    out_lvl_i,
  input  logic [NCH-1:0]    loaded_i,
  output logic [NCH*3-1:0]  mode_o,
  output logic [NCH-1:0]    bcd_o,
  output logic [NCH*2-1:0]  acc_o,
  output logic [NCH-1:0]    load_o,
  output logic [NCH*CW-1:0] init_cnt_o,
  output logic [NCH-1:0]    null_cnt_o
);
  logic [NCH-1:0] cfg_wr, cnt_lat, st_lat, dat_wr, rd_ch;
  logic [DW-1:0]  ch_rdata [NCH];
  chan_cfg_t      ch_cfg   [NCH];

  tmr_ctrl_decode u_dec (
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cfg_wr_o (cfg_wr),
    .cnt_lat_o(cnt_lat),
    .st_lat_o (st_lat),
    .dat_wr_o (dat_wr),
    .rd_o     (rd_ch)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_chan_regs u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_wr_i  (cfg_wr[i]),
      .cnt_lat_i (cnt_lat[i]),
      .st_lat_i  (st_lat[i]),
      .dat_wr_i  (dat_wr[i]),
      .rd_i      (rd_ch[i]),
      .wdata_i   (wdata_i),
      .live_cnt_i(live_cnt_i[i*CW +: CW]),
      .out_lvl_i (out_lvl_i[i]),
      .loaded_i  (loaded_i[i]),
      .cfg_o     (ch_cfg[i]),
      .load_o    (load_o[i]),
      .init_cnt_o(init_cnt_o[i*CW +: CW]),
      .null_cnt_o(null_cnt_o[i]),
      .rdata_o   (ch_rdata[i])
    );
    assign mode_o[i*3 +: 3] = ch_cfg[i].mode;
    assign acc_o[i*2 +: 2]  = ch_cfg[i].acc;
    assign bcd_o[i]         = ch_cfg[i].bcd;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++)
      if (addr_i == AW'(i)) rdata_o = ch_rdata[i];
  end

  // R1
  one_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_wr));
  // R3
  lat_no_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_lat & cfg_wr) == '0);
  // R12
  ctrl_rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && addr_i == CTRL_ADDR |-> rd_ch == '0);
endmodule

// File: tb/sim_tmr_host_port.sv
module sim_tmr_host_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [47:0] live_cnt_i = '0;
  logic [2:0]  out_lvl_i = '0, loaded_i = '0;
  logic [8:0]  mode_o;
  logic [2:0]  bcd_o, load_o, null_cnt_o;
  logic [5:0]  acc_o;
  logic [47:0] init_cnt_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_host_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .live_cnt_i(live_cnt_i),
    .out_lvl_i(out_lvl_i), .loaded_i(loaded_i), .mode_o(mode_o), .bcd_o(bcd_o),
    .acc_o(acc_o), .load_o(load_o), .init_cnt_o(init_cnt_o), .null_cnt_o(null_cnt_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_i = 1'b1; addr_i = a;
    #1 chk(req, {8'h00, rdata_o}, {8'h00, exp});
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic pulse_loaded(input logic [2:0] m);
    @(negedge clk);
    loaded_i = m;
    @(negedge clk);
    loaded_i = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset mode", {7'd0, mode_o}, 16'h0000);
    chk("R1 reset acc", {10'd0, acc_o}, 16'h003f);
    chk("R11 reset null", {13'd0, null_cnt_o}, 16'h0007);
    chk("R4 reset load", {13'd0, load_o}, 16'h0000);
  endtask

  task automatic t_config;
    wr(3, 8'h34);
    wr(3, 8'h97);
    chk("R1 ch0 mode", {13'd0, mode_o[2:0]}, 16'd2);
    chk("R1 ch0 acc", {14'd0, acc_o[1:0]}, 16'd3);
    chk("R1 ch2 mode", {13'd0, mode_o[8:6]}, 16'd3);
    chk("R1 ch2 acc", {14'd0, acc_o[5:4]}, 16'd1);
    chk("R1 bcd", {13'd0, bcd_o}, 16'h0004);
  endtask

  task automatic t_lohi_write;
    wr(0, 8'h34);
    chk("R5 no load after first byte", {15'd0, load_o[0]}, 16'd0);
    wr(0, 8'h12);
    chk("R5 load after second byte", {15'd0, load_o[0]}, 16'd1);
    chk("R5 init count", init_cnt_o[15:0], 16'h1234);
    chk("R11 null set by commit", {15'd0, null_cnt_o[0]}, 16'd1);
    pulse_loaded(3'b001);
    chk("R11 null cleared", {15'd0, null_cnt_o[0]}, 16'd0);
  endtask

  task automatic t_single_write;
    wr(3, 8'h50);
    wr(1, 8'hAB);
    chk("R4 low-only load", {15'd0, load_o[1]}, 16'd1);
    chk("R4 low-only count", init_cnt_o[31:16], 16'h00AB);
    wr(3, 8'h60);
    wr(1, 8'hCD);
    chk("R4 high-only count", init_cnt_o[31:16], 16'hCD00);
  endtask

  task automatic t_live_read;
    live_cnt_i[15:0] = 16'hBEEF;
    rd(0, 8'hEF, "R6 live lo");
    rd(0, 8'hBE, "R6 live hi");
    rd(0, 8'hEF, "R6 live lo again");
    rd(0, 8'hBE, "R6 live hi again");
    live_cnt_i[31:16] = 16'h5678;
    rd(1, 8'h56, "R6 high-only live");
  endtask

  task automatic t_ctrl_read;
    rd(0, 8'hEF, "R12 lo before");
    rd(3, 8'h00, "R12 control read zero");
    rd(0, 8'hBE, "R12 toggle untouched");
  endtask

  task automatic t_count_latch;
    wr(3, 8'h00);
    chk("R3 config kept", {13'd0, mode_o[2:0]}, 16'd2);
    live_cnt_i[15:0] = 16'h1111;
    rd(0, 8'hEF, "R3 latched lo");
    rd(0, 8'hBE, "R3 latched hi");
    rd(0, 8'h11, "R3 live after latch lo");
    rd(0, 8'h11, "R3 live after latch hi");
  endtask

  task automatic t_latch_ignore;
    live_cnt_i[15:0] = 16'h2222;
    wr(3, 8'h00);
    live_cnt_i[15:0] = 16'h3333;
    rd(0, 8'h22, "R7 first byte");
    wr(3, 8'h00);
    rd(0, 8'h22, "R7 second latch ignored");
    rd(0, 8'h33, "R7 live resumes lo");
    rd(0, 8'h33, "R7 live resumes hi");
  endtask

  task automatic t_high_latch;
    live_cnt_i[31:16] = 16'h5678;
    wr(3, 8'h40);
    live_cnt_i[31:16] = 16'h9ABC;
    rd(1, 8'h56, "R6 high-only latched byte");
    rd(1, 8'h9A, "R6 high-only live after");
  endtask

  task automatic t_status;
    out_lvl_i[0] = 1'b1;
    wr(3, 8'hE2);
    rd(0, 8'hB4, "R9 status layout");
    rd(0, 8'h33, "R8 status read keeps toggle lo");
    rd(0, 8'h33, "R8 then hi");
  endtask

  task automatic t_cfg_clears;
    out_lvl_i[2] = 1'b1;
    wr(3, 8'h90);
    wr(3, 8'hE8);
    rd(2, 8'h50, "R2 mode0 output low, null set");
    wr(3, 8'h00);
    wr(3, 8'h34);
    live_cnt_i[15:0] = 16'h4444;
    rd(0, 8'h44, "R2 latch discarded lo");
    rd(0, 8'h44, "R2 latch discarded hi");
    wr(3, 8'hE2);
    rd(0, 8'hF4, "R2 nonzero mode output high");
  endtask

  task automatic t_readback_multi;
    out_lvl_i = '0;
    pulse_loaded(3'b111);
    live_cnt_i = {16'h0506, 16'h0304, 16'h0102};
    wr(3, 8'hCE);
    live_cnt_i = '0;
    rd(0, 8'h34, "R8 ch0 status first");
    rd(0, 8'h02, "R8 ch0 count lo");
    rd(0, 8'h01, "R8 ch0 count hi");
    rd(1, 8'h20, "R8 ch1 status");
    rd(1, 8'h03, "R8 ch1 count");
    rd(2, 8'h10, "R8 ch2 status");
    rd(2, 8'h06, "R8 ch2 count");
    live_cnt_i[31:16] = 16'h0708;
    wr(3, 8'hD4);
    live_cnt_i = {16'h0000, 16'h0000, 16'hAAAA};
    rd(1, 8'h07, "R8 count only ch1");
    rd(0, 8'hAA, "R8 unselected ch0 live lo");
    rd(0, 8'hAA, "R8 unselected ch0 live hi");
  endtask

  task automatic t_decimal;
    wr(3, 8'hB1);
    wr(2, 8'h34);
    wr(2, 8'h12);
    chk("R10 decimal write", init_cnt_o[47:32], 16'd1234);
    live_cnt_i[47:32] = 16'd9876;
    rd(2, 8'h76, "R10 decimal live lo");
    rd(2, 8'h98, "R10 decimal live hi");
    wr(3, 8'h80);
    live_cnt_i[47:32] = 16'd0;
    rd(2, 8'h76, "R10 decimal latched lo");
    rd(2, 8'h98, "R10 decimal latched hi");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_config;
    t_lohi_write;
    t_single_write;
    t_live_read;
    t_ctrl_read;
    t_count_latch;
    t_latch_ignore;
    t_high_latch;
    t_status;
    t_cfg_clears;
    t_readback_multi;
    t_decimal;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule